// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory bus. It holds a byte array behind a 16-bit address counter. The block samples SCL and SDA with its own system clock and finds start and stop conditions. It then decodes a control byte that carries a device code, three select bits and a direction bit. When that byte names this device, the block acknowledges it. It then takes a two-byte address and stores the data bytes that follow, or it shifts out array bytes from the current address.

The block never drives SCL. It drives SDA only low, through a single output enable, and the pull-up outside the block returns the line high. Two strap inputs let four devices share one bus. A fixed select input must be held high or the block stays silent. A protect input stops the array from changing. Protected writes are still acknowledged, and reads are not affected. Addresses above the array size alias onto the array by their low bits.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The control byte has the device code 1010 in bits 7..4, a 1 in bit 3, the strap value in bits 2..1 and the direction in bit 0 (1 = read). The block acknowledges it only when every field matches. On any mismatch it sends no acknowledge and ignores traffic until the next start.
- R2: The block compares control-byte bits 2..1 with the two strap inputs. For each of the four strap settings it acknowledges only the matching value.
- R3: While the fixed select input is low, the block never acknowledges, never drives SDA and never writes the array.
- R4: An SDA fall while SCL is high is a start. An SDA rise while SCL is high is a stop. After a stop, bytes clocked without a new start get no acknowledge. The block changes its own SDA drive only while SCL is low.
- R5: After a write control byte, the block acknowledges a high address byte, then a low address byte, then each data byte. Each data byte is stored at the current address, and the address then increments.
- R6: The address counter wraps from FFFFh to 0000h during sequential writes and reads.
- R7: While write-protect is high, every write byte is still acknowledged but no array location changes. Reads are unaffected.
- R8: A random read loads the address with a write control byte and two address bytes, then uses a repeated start and a read control byte. The block returns the byte at that address MSB first. Each byte the master acknowledges is followed by the next address.
- R9: A current-address read, which is a read control byte with no address phase, returns the byte after the last byte accessed.
- R10: When the master does not acknowledge a read byte, the block releases SDA and ignores further clocks until the next start. Bits clocked in that state read as 1.
- R11: A repeated start at any point drops the transfer in progress and restarts control-byte decoding. A partly received data byte is not stored.
- R12: After reset the SDA output enable is low, and the block drives SDA only low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 2 | Device select straps, tie low when unused |
| csel_i | input | 1 | Fixed select, must be high for operation |
| wp_i | input | 1 | Write protect, high blocks array writes |
| sda_oe_o | output | 1 | When high, pull SDA low |

## Verification
The bench builds the block with a 256-byte array and the 16-bit address counter. With this small array, addresses such as FFFFh, 00FFh and 0000h fall on array indices that the bench can follow, so it can check both the counter wrap and the low-bit aliasing with short transfers. The bench uses a bus quarter-period of eight system clocks. This leaves room for the three-stage input sampling, so SDA turns are always observed while SCL is low.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int         MEM_BYTES = 256,
  parameter logic [3:0] DEV_CODE  = 4'b1010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic       csel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int ADDR_W = 16;
  localparam int IDX_W  = $clog2(MEM_BYTES);

  typedef enum logic [2:0] {ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WR, ST_RD} st_t;

  logic [2:0] scl_sy, sda_sy;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  wire scl_s     = scl_sy[1];
  wire scl_p     = scl_sy[2];
  wire sda_s     = sda_sy[1];
  wire sda_p     = sda_sy[2];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  st_t               state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [ADDR_W-1:0] addr;
  logic              nack;
  logic [7:0]        mem [MEM_BYTES];

  wire [IDX_W-1:0] idx     = addr[IDX_W-1:0];
  wire [7:0]       rd_byte = mem[idx];
  wire [2:0]       rd_sel  = 3'd7 - bitcnt[2:0];
  wire ctrl_ok = (shreg[7:4] == DEV_CODE) && shreg[3] && (shreg[2:1] == strap_i);
  wire mem_we  = csel_i & scl_fall & (state == ST_WR) & (bitcnt == 4'd8) & ~wp_i;

  always_ff @(posedge clk_i)
    if (mem_we) mem[idx] <= shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      addr     <= '0;
      nack     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (!csel_i) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state    <= ST_CTRL;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (state != ST_RD) shreg <= {shreg[6:0], sda_s};
        end else if (bitcnt == 4'd8 && state == ST_RD) begin
          nack   <= sda_s;
          bitcnt <= 4'd9;
        end
      end
      if (scl_fall) begin
        if (bitcnt == 4'd9) begin
          bitcnt   <= '0;
          sda_oe_o <= 1'b0;
          if (state == ST_RD) begin
            if (nack) state <= ST_IDLE;
            else sda_oe_o <= ~rd_byte[7];
          end
        end else if (bitcnt == 4'd8) begin
          if (state == ST_RD) begin
            sda_oe_o <= 1'b0;
            addr     <= addr + 1'b1;
          end else begin
            bitcnt   <= 4'd9;
            sda_oe_o <= 1'b1;
            case (state)
              ST_CTRL: begin
                nack <= 1'b0;
                if (ctrl_ok) state <= shreg[0] ? ST_RD : ST_AHI;
                else begin
                  state    <= ST_IDLE;
                  bitcnt   <= '0;
                  sda_oe_o <= 1'b0;
                end
              end
              ST_AHI: begin
                addr[15:8] <= shreg;
                state      <= ST_ALO;
              end
              ST_ALO: begin
                addr[7:0] <= shreg;
                state     <= ST_WR;
              end
              default: addr <= addr + 1'b1;
            endcase
          end
        end else if (state == ST_RD && bitcnt != 4'd0) begin
          sda_oe_o <= ~rd_byte[rd_sel];
        end
      end
    end
  end

  // R3
  csel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csel_i |=> !sda_oe_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe_o);

  // R4
  scl_low_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csel_i && $past(csel_i) && !$stable(sda_oe_o) |-> !scl_s);

  // R11
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det && csel_i |=> state == ST_CTRL && bitcnt == 4'd0);

  // R10
  ack_slot_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csel_i && state == ST_RD && scl_fall && bitcnt == 4'd8 && !start_det && !stop_det
      |=> !sda_oe_o);
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb_top;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       msda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       csel = 1'b1;
  logic       wp = 1'b0;
  logic       sda_oe;
  wire        sda_bus = msda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_eeprom_slave #(.MEM_BYTES(256)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(strap), .csel_i(csel), .wp_i(wp), .sda_oe_o(sda_oe));

  // {wp, addr, wdata, expected readback}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 16'h0010, 8'hA5, 8'hA5},
    {1'b0, 16'h1234, 8'h3C, 8'h3C},
    {1'b0, 16'h00FF, 8'h80, 8'h80},
    {1'b1, 16'h0010, 8'h11, 8'hA5},
    {1'b0, 16'hABCD, 8'h01, 8'h01},
    {1'b1, 16'h1234, 8'hFF, 8'h3C}
  };

  function automatic logic [7:0] ctl(input logic rw);
    return {4'b1010, 1'b1, strap, rw};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    msda = 1'b1; q(); scl = 1'b1; q(); msda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic stop_c();
    msda = 1'b0; q(); scl = 1'b1; q(); msda = 1'b1; q();
  endtask

  task automatic clock_bit(input logic b, output logic s);
    msda = b; q(); scl = 1'b1; q(); s = sda_bus; q(); scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [23:0] d, input int n,
                          output logic ok);
    logic ack;
    start_c();
    send_byte(ctl(1'b0), ack); ok = ack;
    send_byte(a[15:8], ack);   ok &= ack;
    send_byte(a[7:0], ack);    ok &= ack;
    for (int k = 0; k < n; k++) begin
      send_byte(d[23-8*k -: 8], ack);
      ok &= ack;
    end
    stop_c();
  endtask

  task automatic do_read(input logic [15:0] a, input int n, output logic [23:0] r,
                         output logic ok);
    logic ack;
    logic [7:0] b;
    r = '0;
    start_c();
    send_byte(ctl(1'b0), ack); ok = ack;
    send_byte(a[15:8], ack);   ok &= ack;
    send_byte(a[7:0], ack);    ok &= ack;
    start_c();
    send_byte(ctl(1'b1), ack); ok &= ack;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      r[23-8*k -: 8] = b;
    end
    stop_c();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    logic ok, ack;
    logic [23:0] r;
    logic [7:0] b;
    logic s;

    repeat (5) @(negedge clk);
    chk("R12 reset release", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      wp = VEC[v][32];
      do_write(VEC[v][31:16], {VEC[v][15:8], 16'h0}, 1, ok);
      chk("R5/R7 write acks", {31'd0, ok}, 32'd1);
      wp = 1'b0;
      do_read(VEC[v][31:16], 1, r, ok);
      chk("R8/R7 readback", {23'd0, ok, r[23:16]}, {23'd0, 1'b1, VEC[v][7:0]});
    end

    do_write(16'h0040, 24'h112233, 3, ok);
    chk("R5 sequential write acks", {31'd0, ok}, 32'd1);
    do_read(16'h0040, 2, r, ok);
    chk("R8 sequential read", {7'd0, ok, r}, {7'd0, 1'b1, 24'h112200});
    start_c(); send_byte(ctl(1'b1), ack); recv_byte(1'b0, b); stop_c();
    chk("R9 current address read", {23'd0, ack, b}, {23'd0, 1'b1, 8'h33});

    start_c(); send_byte(ctl(1'b1), ack); recv_byte(1'b0, b);
    recv_byte(1'b0, b);
    chk("R10 released after nack", {24'd0, b}, 32'h0000_00FF);
    chk("R10 no drive after nack", {31'd0, sda_oe}, 32'd0);
    stop_c();

    do_write(16'hFFFF, 24'h5A6B00, 2, ok);
    do_read(16'hFFFF, 2, r, ok);
    chk("R6 wrap write/read", {7'd0, ok, r[23:8]}, {7'd0, 1'b1, 16'h5A6B});
    do_read(16'h0000, 1, r, ok);
    chk("R6 wrapped byte at 0000", {24'd0, r[23:16]}, 32'h0000_006B);

    for (int sv = 0; sv < 4; sv++) begin
      strap = 2'(sv);
      start_c(); send_byte({4'b1010, 1'b1, 2'(sv), 1'b0}, ack); stop_c();
      chk("R2 strap match acks", {31'd0, ack}, 32'd1);
      start_c(); send_byte({4'b1010, 1'b1, 2'(sv ^ 1), 1'b0}, ack); stop_c();
      chk("R2 strap mismatch silent", {31'd0, ack}, 32'd0);
    end
    strap = 2'b01;

    start_c(); send_byte({4'b1011, 1'b1, strap, 1'b0}, ack); stop_c();
    chk("R1 wrong device code", {31'd0, ack}, 32'd0);
    start_c(); send_byte({4'b1010, 1'b0, strap, 1'b0}, ack); stop_c();
    chk("R1 select bit 3 low", {31'd0, ack}, 32'd0);
    start_c(); send_byte(8'h00, ack); send_byte(ctl(1'b0), ack); stop_c();
    chk("R1 idle until next start", {31'd0, ack}, 32'd0);

    csel = 1'b0;
    do_write(16'h0040, 24'h990000, 1, ok);
    chk("R3 no ack when deselected", {31'd0, ok}, 32'd0);
    csel = 1'b1;
    do_read(16'h0040, 1, r, ok);
    chk("R3 array untouched", {24'd0, r[23:16]}, 32'h0000_0011);

    send_byte(ctl(1'b0), ack);
    chk("R4 no start after stop", {31'd0, ack}, 32'd0);
    q();

    start_c();
    send_byte(ctl(1'b0), ack); send_byte(8'h00, ack); send_byte(8'h40, ack);
    for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
    start_c();
    send_byte(ctl(1'b1), ack);
    recv_byte(1'b0, b);
    stop_c();
    chk("R11 repeated start restart", {23'd0, ack, b}, {23'd0, 1'b1, 8'h11});

    finish_run();
  end
endmodule